// File: doc/BRIEF.md
# Scannable Registered Bus Transceiver

This block is a small registered transceiver with two register banks of equal width. The transmit bank captures the A-side data word and drives a shared bus. The receive bank captures the B-side data word and presents it on the receive outputs. Each bank has its own load control; with load low, the bank feeds its own output back to its input and keeps its value. A scan control joins both banks into one serial shift chain. The chain starts at a serial input and ends at the top bit of the receive outputs.

Bus drive is modelled as a data word plus a per-bit output enable. A bit is driven only when it is high and the bus is active, so a low bit is never driven. A single enable flip-flop gates the bus. The flip-flop loads a synchronous enable request on the clock. An asynchronous kill input clears it and blanks the bus at once. An active-low asynchronous set input overrides the flip-flop, so the bus can be re-enabled either on a clock edge or with no clock at all.

Top module: `scan_bus_xcvr`

## Requirements
- R1: With `scan_mode` low and `tx_load` high, the transmit bank takes `a_in` on the rising clock edge, and the new value reaches the bus after that edge.
- R2: With `scan_mode` low and `tx_load` low, the transmit bank keeps its value across clock edges, whatever `a_in` is.
- R3: With `scan_mode` low, the receive bank takes `b_in` on the edge when `rx_load` is high and keeps its value when `rx_load` is low. It is seen on `q_out` after that edge.
- R4: With `scan_mode` high, each edge shifts one chain made of transmit bits 0 to WIDTH-1 followed by receive bits 0 to WIDTH-1. `scan_in` enters transmit bit 0, and the tail appears on `q_out[WIDTH-1]`. `tx_load`, `rx_load`, `a_in` and `b_in` are ignored, and the bus-enable flip-flop keeps its value.
- R5: With `scan_mode` low, `bus_kill` low and `sync_set_n` high, the bus-enable flip-flop takes `bus_en_req` on each rising edge.
- R6: Raising `bus_kill` forces every `bus_oe` bit and every `bus_data` bit to 0 with no clock edge, and clears the enable flip-flop. Once `bus_kill` is released with `sync_set_n` high, the bus stays off until an edge samples `bus_en_req` high.
- R7: Holding `sync_set_n` low sets the enable flip-flop with no clock edge. Releasing `bus_kill` in that state turns the bus back on at once.
- R8: When the bus is active (flip-flop set and `bus_kill` low), `bus_data` equals the transmit bank and `bus_oe[i]` is 1 exactly where the transmit bit i is 1. When the bus is not active, both are all zeros.
- R9: After reset, both banks hold zero and the enable flip-flop is clear, so `q_out`, `bus_data` and `bus_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Transmit-side data word |
| b_in | input | WIDTH | Receive-side data word |
| scan_in | input | 1 | Serial data into the scan chain |
| tx_load | input | 1 | Transmit bank load (1) / hold (0) |
| rx_load | input | 1 | Receive bank load (1) / hold (0) |
| scan_mode | input | 1 | 1 selects serial shifting through both banks |
| bus_kill | input | 1 | Asynchronous bus disable, active high |
| bus_en_req | input | 1 | Synchronous bus enable request |
| sync_set_n | input | 1 | Active-low asynchronous set of the enable flip-flop |
| bus_data | output | WIDTH | Value driven on the bus |
| bus_oe | output | WIDTH | Per-bit bus drive enable |
| q_out | output | WIDTH | Receive bank output; top bit is the scan tail |

## Verification
The bench builds the block with the default WIDTH of 3, so the whole six-bit scan chain fits in six shifts. With that width, every bit of a known start pattern can be seen leaving at the top receive bit in order. The same width gives bus words with mixed high and low bits, so the rule that only high bits are driven is checked bit by bit. The asynchronous kill and set inputs are driven between clock edges and sampled before the next edge, which separates immediate effects from clocked ones.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

  typedef enum logic [1:0] {
    BK_HOLD  = 2'd0,
    BK_LOAD  = 2'd1,
    BK_SHIFT = 2'd2
  } bank_op_e;

  // Scan takes precedence over the load control.
  function automatic bank_op_e pick_op(input logic scan, input logic load);
    if (scan)      return BK_SHIFT;
    else if (load) return BK_LOAD;
    else           return BK_HOLD;
  endfunction

  // Bus is live only with the enable flop set and no kill request.
  function automatic logic bus_live(input logic en_q, input logic kill);
    return en_q & ~kill;
  endfunction

endpackage

// File: rtl/xcvr_bank.sv
`timescale 1ns/1ps
module xcvr_bank
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_mode,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             sin,
  output logic [WIDTH-1:0] q,
  output logic             sout
);

  bank_op_e op;
  logic [WIDTH-1:0] shifted;

  assign op = pick_op(scan_mode, load);

  generate
    if (WIDTH > 1) begin : g_wide
      assign shifted = {q[WIDTH-2:0], sin};
    end else begin : g_narrow
      assign shifted = sin;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      case (op)
        BK_LOAD:  q <= din;
        BK_SHIFT: q <= shifted;
        default:  q <= q;
      endcase
    end
  end

  assign sout = q[WIDTH-1];

  // R1 / R3: a load edge captures the data word
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_mode && load) |=> (q == $past(din)));

  // R2 / R3: loopback keeps the value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_mode && !load) |=> $stable(q));

  // R4: one-place shift with the serial bit entering at bit 0
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |=> (q[0] == $past(sin)));

  a_r4_tail: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |=> (sout == $past(q[WIDTH-1 - ((WIDTH > 1) ? 1 : 0)]) || WIDTH == 1));

endmodule

// File: rtl/xcvr_bus_en.sv
`timescale 1ns/1ps
module xcvr_bus_en
  import xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scan_mode,
  input  logic bus_kill,
  input  logic bus_en_req,
  input  logic sync_set_n,
  output logic en_q,
  output logic active
);

  // Priority: reset, then the overriding set, then the kill clear.
  always_ff @(posedge clk or negedge rst_n or negedge sync_set_n or posedge bus_kill) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (!sync_set_n) begin
      en_q <= 1'b1;
    end else if (bus_kill) begin
      en_q <= 1'b0;
    end else if (!scan_mode) begin
      en_q <= bus_en_req;
    end
  end

  assign active = bus_live(en_q, bus_kill);

  // R5: clocked capture of the request
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_set_n && !bus_kill && !scan_mode) ##1 (sync_set_n && !bus_kill)
      |-> (en_q == $past(bus_en_req)));

  // R7: the set input wins over everything but reset
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_set_n |-> en_q);

  // R6: kill leaves the flop clear while the set is idle
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_kill && sync_set_n) |-> !en_q);

  // R4: flop keeps its state while scanning
  a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode && sync_set_n && !bus_kill) ##1 (sync_set_n && !bus_kill)
      |-> $stable(en_q));

endmodule

// File: rtl/xcvr_bus_drive.sv
`timescale 1ns/1ps
module xcvr_bus_drive #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] tx_q,
  input  logic             active,
  output logic [WIDTH-1:0] bus_data,
  output logic [WIDTH-1:0] bus_oe
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      // A low bit is in cutoff: never driven.
      assign bus_data[i] = tx_q[i] & active;
      assign bus_oe[i]   = tx_q[i] & active;
    end
  endgenerate

endmodule

// File: rtl/scan_bus_xcvr.sv
`timescale 1ns/1ps
module scan_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             scan_in,
  input  logic             tx_load,
  input  logic             rx_load,
  input  logic             scan_mode,
  input  logic             bus_kill,
  input  logic             bus_en_req,
  input  logic             sync_set_n,
  output logic [WIDTH-1:0] bus_data,
  output logic [WIDTH-1:0] bus_oe,
  output logic [WIDTH-1:0] q_out
);

  logic [WIDTH-1:0] tx_q;
  logic [WIDTH-1:0] rx_q;
  logic             tx_tail;
  logic             rx_tail;
  logic             en_q;
  logic             bus_active;

  xcvr_bank #(.WIDTH(WIDTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .load(tx_load),
    .din(a_in), .sin(scan_in), .q(tx_q), .sout(tx_tail)
  );

  xcvr_bank #(.WIDTH(WIDTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .load(rx_load),
    .din(b_in), .sin(tx_tail), .q(rx_q), .sout(rx_tail)
  );

  xcvr_bus_en u_en (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .bus_kill(bus_kill),
    .bus_en_req(bus_en_req), .sync_set_n(sync_set_n),
    .en_q(en_q), .active(bus_active)
  );

  xcvr_bus_drive #(.WIDTH(WIDTH)) u_drv (
    .tx_q(tx_q), .active(bus_active), .bus_data(bus_data), .bus_oe(bus_oe)
  );

  assign q_out = rx_q;

  // R8: a killed bus drives nothing
  a_r8_kill_off: assert property (@(posedge clk) disable iff (!rst_n)
    bus_kill |-> (bus_oe == '0 && bus_data == '0));

  // R8: an enabled bit always carries a high level
  a_r8_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_oe & ~bus_data) == '0));

  // R8: flop clear means no drive
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (bus_oe == '0));

  // R4: the scan tail is the top receive output
  a_r4_tail_out: assert property (@(posedge clk) disable iff (!rst_n)
    scan_mode |=> (q_out[WIDTH-1] == $past(rx_q[(WIDTH > 1) ? WIDTH-2 : 0]) || WIDTH == 1));

endmodule

// File: tb/scan_bus_xcvr_bench.sv
`timescale 1ns/1ps
module scan_bus_xcvr_bench;

  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         scan_in = 1'b0;
  logic         tx_load = 1'b0;
  logic         rx_load = 1'b0;
  logic         scan_mode = 1'b0;
  logic         bus_kill = 1'b0;
  logic         bus_en_req = 1'b0;
  logic         sync_set_n = 1'b1;
  logic [W-1:0] bus_data;
  logic [W-1:0] bus_oe;
  logic [W-1:0] q_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scan_bus_xcvr #(.WIDTH(W)) u_scan_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .scan_in(scan_in),
    .tx_load(tx_load), .rx_load(rx_load), .scan_mode(scan_mode),
    .bus_kill(bus_kill), .bus_en_req(bus_en_req), .sync_set_n(sync_set_n),
    .bus_data(bus_data), .bus_oe(bus_oe), .q_out(q_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one rising edge, then sample 1 ns later
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // move to the falling edge to drive inputs
  task automatic to_neg();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk("R9 q_out", q_out, 0);
    chk("R9 bus_data", bus_data, 0);
    chk("R9 bus_oe", bus_oe, 0);
    to_neg();
    rst_n = 1'b1;
  endtask

  task automatic t_tx_path();
    to_neg();
    bus_en_req = 1'b1; tx_load = 1'b1; a_in = 3'b111;
    tick();
    chk("R1/R5 bus_data load", bus_data, 3'b111);
    chk("R5 bus_oe enabled", bus_oe, 3'b111);
    to_neg();
    a_in = 3'b010;
    tick();
    chk("R8 bus_data mixed", bus_data, 3'b010);
    chk("R8 bus_oe only high bits", bus_oe, 3'b010);
    to_neg();
    tx_load = 1'b0; a_in = 3'b101;
    tick();
    chk("R2 hold bus_data", bus_data, 3'b010);
    to_neg();
    bus_en_req = 1'b0;
    tick();
    chk("R5 sync disable oe", bus_oe, 0);
    chk("R8 idle data", bus_data, 0);
  endtask

  task automatic t_rx_path();
    to_neg();
    rx_load = 1'b1; b_in = 3'b110;
    tick();
    chk("R3 rx load", q_out, 3'b110);
    to_neg();
    rx_load = 1'b0; b_in = 3'b001;
    tick();
    chk("R3 rx hold", q_out, 3'b110);
  endtask

  task automatic t_kill();
    to_neg();
    bus_en_req = 1'b1;
    tick();
    chk("R5 re-enable", bus_oe, 3'b010);
    to_neg();
    bus_kill = 1'b1;
    #1;
    chk("R6 immediate kill oe", bus_oe, 0);
    chk("R6 immediate kill data", bus_data, 0);
    tick();
    chk("R6 kill held", bus_oe, 0);
    to_neg();
    bus_en_req = 1'b0;
    bus_kill = 1'b0;
    #1;
    chk("R6 stays off after release", bus_oe, 0);
    tick();
    chk("R6 off with request low", bus_oe, 0);
    to_neg();
    bus_en_req = 1'b1;
    tick();
    chk("R6 clocked re-enable", bus_oe, 3'b010);
  endtask

  task automatic t_async();
    to_neg();
    bus_en_req = 1'b0;
    tick();
    chk("R5 off before set", bus_oe, 0);
    to_neg();
    sync_set_n = 1'b0;
    #1;
    chk("R7 set without clock", bus_oe, 3'b010);
    bus_kill = 1'b1;
    #1;
    chk("R6 kill over set", bus_oe, 0);
    bus_kill = 1'b0;
    #1;
    chk("R7 async re-enable", bus_oe, 3'b010);
    tick();
    chk("R7 set overrides request", bus_oe, 3'b010);
    to_neg();
    sync_set_n = 1'b1;
    tick();
    chk("R5 capture after set released", bus_oe, 0);
  endtask

  task automatic t_scan();
    logic [2*W-1:0] chain;
    logic [5:0] pattern;
    pattern = 6'b101100;
    chain = {q_out, 3'b010};
    to_neg();
    scan_mode = 1'b1; tx_load = 1'b1; rx_load = 1'b1;
    a_in = 3'b111; b_in = 3'b000; bus_en_req = 1'b1;
    for (int k = 0; k < 2*W; k++) begin
      scan_in = pattern[2*W-1-k];
      tick();
      chain = {chain[2*W-2:0], pattern[2*W-1-k]};
      chk("R4 scan tail", q_out[W-1], chain[2*W-1]);
      chk("R4 rx bank during scan", q_out, chain[2*W-1:W]);
      chk("R4 enable held in scan", bus_oe, 0);
      to_neg();
    end
    scan_mode = 1'b0; tx_load = 1'b0; rx_load = 1'b0;
    tick();
    chk("R4 rx after scan", q_out, 3'b101);
    chk("R4 tx after scan", bus_data, 3'b100);
    chk("R8 oe after scan", bus_oe, 3'b100);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_path();
    t_rx_path();
    t_kill();
    t_async();
    t_scan();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule